// File: doc/BRIEF.md
# Programmable PCI Hole Address Decoder

This block routes memory addresses inside a host bridge. A 32-bit hole-base register, written through a byte-enabled configuration port, sets where PCI memory starts below 4 GiB. Everything from that base up to 4 GiB is the low PCI hole. RAM that would have sat in that range is moved above 4 GiB. A 64-bit PCI hole of 2^62 bytes then starts right after the moved RAM. A fixed legacy window at 0xA0000 is always sent to PCI, and it wins over RAM.

Lookups enter on a valid/ready stream and leave on a valid/ready result stream with one register of latency. Back-pressure rule: an address is accepted in a cycle where `lk_valid` and `lk_ready` are both high. `lk_ready` is high when the result slot is empty or is being drained in that same cycle (`rs_ready` high). A result that is not taken stays unchanged on the outputs. The configuration port, the RAM size and the reset-value strap are plain control pins.

Top module: `pci_hole_decoder`

## Requirements
- R1: After reset the hole base reads 0xE000_0000, or 0xF000_0000 when `strap_alt_base` is high during reset.
- R2: A write to dword index 0x2C (byte offsets 0xB0 to 0xB3) updates only the byte lanes whose enable is set. Lane 0 / `cfg_be[0]` holds bits 7:0 and lane 3 holds bits 31:24. A write to any other index leaves the base unchanged.
- R3: One cycle after `cfg_rd`, `cfg_rdata` shows the whole base value exactly as written, or zero for any other index. It then holds until the next read.
- R4: A new base first affects lookups accepted in the cycle after the write. A lookup accepted in the same cycle as the write uses the old base.
- R5: An address in [0xA0000, 0xC0000) yields target 2 (legacy, routed to PCI), whatever the RAM and base.
- R6: An address below 4 GiB and at or above the base yields target 1 (PCI).
- R7: An address below the base and below the RAM size yields target 0 (DRAM) with offset equal to the address.
- R8: The relocated amount is RAM size minus base when RAM size is at least the base, otherwise zero. An address in [4 GiB, 4 GiB + relocated) yields target 0 with offset address minus 4 GiB plus base.
- R9: An address in [4 GiB + relocated, 4 GiB + relocated + 2^62) yields target 1. When parameter `NARROW_ADDR` is set, no address at or above 4 GiB yields target 1.
- R10: Any other address yields target 3 with `rs_unmapped` high. For targets 0, 1 and 2, `rs_unmapped` is low.
- R11: `lk_ready` equals not `rs_valid` or `rs_ready`. An accepted lookup appears on the result port on the next cycle. A result held under back-pressure keeps its target and offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_alt_base | input | 1 | Selects the alternate reset base |
| ram_size | input | 64 | Installed RAM size in bytes (static) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_idx | input | 6 | Configuration dword index |
| cfg_be | input | 4 | Byte enables for a write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid the cycle after `cfg_rd` |
| lk_valid | input | 1 | Lookup address valid |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_addr | input | 64 | Address to classify |
| rs_valid | output | 1 | Result valid |
| rs_ready | input | 1 | Result consumer ready |
| rs_target | output | 2 | 0 DRAM, 1 PCI, 2 legacy window, 3 none |
| rs_unmapped | output | 1 | Address hit no window |
| rs_offset | output | 64 | DRAM offset when target is 0, else zero |

## Verification
The assertions check these properties on every cycle:
- A result stalled by back-pressure stays unchanged.
- Unselected register lanes and non-matching indexes leave the base unchanged.
- Legacy-window addresses map to the legacy target.
- Any accepted address in the low hole maps to PCI.
- In narrow mode, PCI is never produced above 4 GiB.

Some behaviours show up only in the bench's scenarios, where a behavioural model is compared on every clock:
- The exact relocation arithmetic on each side of the RAM/base comparison.
- The old-base result for a lookup that coincides with a write.
- The strap-selected reset value.
- Readback of partially written bytes.

// File: rtl/pci_hole_pkg.sv
package pci_hole_pkg;
  typedef enum logic [1:0] {
    TGT_DRAM   = 2'd0,
    TGT_PCI    = 2'd1,
    TGT_LEGACY = 2'd2,
    TGT_NONE   = 2'd3
  } tgt_e;

  localparam logic [31:0] BASE_DEFAULT = 32'hE000_0000;
  localparam logic [31:0] BASE_ALT     = 32'hF000_0000;
  localparam int          HOLE_REG_IDX = 'h2C;   // byte offset 0xB0 / 4
  localparam logic [63:0] LEGACY_LO    = 64'h0000_0000_000A_0000;
  localparam logic [63:0] LEGACY_SIZE  = 64'h0000_0000_0002_0000;
endpackage

// File: rtl/hole_base_reg.sv
module hole_base_reg
  import pci_hole_pkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int LANES   = 4,
  parameter int REG_IDX = HOLE_REG_IDX
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strap_alt,
  input  logic               wr,
  input  logic               rd,
  input  logic [IDX_W-1:0]   idx,
  input  logic [LANES-1:0]   be,
  input  logic [8*LANES-1:0] wdata,
  output logic [8*LANES-1:0] base_o,
  output logic [8*LANES-1:0] rdata_o
);
  localparam int DW = 8 * LANES;

  logic          hit;
  logic [DW-1:0] rst_val;

  assign hit     = (idx == IDX_W'(REG_IDX));
  assign rst_val = strap_alt ? DW'(BASE_ALT) : DW'(BASE_DEFAULT);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                base_o[8*g +: 8] <= rst_val[8*g +: 8];
      else if (wr && hit && be[g]) base_o[8*g +: 8] <= wdata[8*g +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_o <= '0;
    else if (rd) rdata_o <= hit ? base_o : '0;
  end

  a_r2_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && hit) |=> $stable(base_o));
  a_r2_top_lane_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit && !be[LANES-1]) |=> $stable(base_o[DW-1 -: 8]));
  a_r3_other_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !hit) |=> (rdata_o == '0));
endmodule

// File: rtl/hole_window_calc.sv
module hole_window_calc #(
  parameter int ADDR_W    = 64,
  parameter int BASE_W    = 32,
  parameter int SPAN_LOG2 = 62,
  parameter bit NARROW    = 1'b0
) (
  input  logic [BASE_W-1:0] base,
  input  logic [ADDR_W-1:0] ram_size,
  output logic [ADDR_W:0]   reloc_end,
  output logic [ADDR_W:0]   hi_end,
  output logic              hi_en
);
  localparam logic [ADDR_W:0] FOUR_G = (ADDR_W+1)'(1) << BASE_W;
  localparam logic [ADDR_W:0] SPAN   = (ADDR_W+1)'(1) << SPAN_LOG2;

  logic [ADDR_W:0] base_x;
  logic [ADDR_W:0] ram_x;
  logic [ADDR_W:0] reloc;

  assign base_x = (ADDR_W+1)'(base);
  assign ram_x  = (ADDR_W+1)'(ram_size);

  always_comb begin
    if (ram_x >= base_x) reloc = ram_x - base_x;
    else                 reloc = '0;
  end

  assign reloc_end = FOUR_G + reloc;
  assign hi_end    = reloc_end + SPAN;

  if (NARROW) begin : g_narrow
    assign hi_en = 1'b0;
  end else begin : g_wide
    assign hi_en = 1'b1;
  end
endmodule

// File: rtl/addr_classifier.sv
module addr_classifier
  import pci_hole_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int BASE_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BASE_W-1:0] base,
  input  logic [ADDR_W-1:0] ram_size,
  input  logic [ADDR_W:0]   reloc_end,
  input  logic [ADDR_W:0]   hi_end,
  input  logic              hi_en,
  output tgt_e              tgt,
  output logic [ADDR_W-1:0] offset
);
  localparam logic [ADDR_W:0] FOUR_G = (ADDR_W+1)'(1) << BASE_W;
  localparam logic [ADDR_W:0] LEG_LO = (ADDR_W+1)'(LEGACY_LO);
  localparam logic [ADDR_W:0] LEG_HI = (ADDR_W+1)'(LEGACY_LO + LEGACY_SIZE);

  logic [ADDR_W:0] a_x;
  logic [ADDR_W:0] base_x;
  logic            in_legacy;
  logic            below_4g;

  assign a_x       = (ADDR_W+1)'(addr);
  assign base_x    = (ADDR_W+1)'(base);
  assign in_legacy = (a_x >= LEG_LO) && (a_x < LEG_HI);
  assign below_4g  = (a_x < FOUR_G);

  always_comb begin
    tgt    = TGT_NONE;
    offset = '0;
    if (in_legacy) begin
      tgt = TGT_LEGACY;
    end else if (below_4g) begin
      if (a_x >= base_x) begin
        tgt = TGT_PCI;
      end else if (addr < ram_size) begin
        tgt    = TGT_DRAM;
        offset = addr;
      end
    end else if (a_x < reloc_end) begin
      tgt    = TGT_DRAM;
      offset = ADDR_W'(a_x - FOUR_G + base_x);
    end else if (hi_en && (a_x < hi_end)) begin
      tgt = TGT_PCI;
    end
  end
endmodule

// File: rtl/pci_hole_decoder.sv
module pci_hole_decoder
  import pci_hole_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int IDX_W       = 6,
  parameter int SPAN_LOG2   = 62,
  parameter bit NARROW_ADDR = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_alt_base,
  input  logic [ADDR_W-1:0] ram_size,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              rs_valid,
  input  logic              rs_ready,
  output logic [1:0]        rs_target,
  output logic              rs_unmapped,
  output logic [ADDR_W-1:0] rs_offset
);
  localparam int BASE_W = 32;
  localparam logic [ADDR_W-1:0] LEG_END = ADDR_W'(LEGACY_LO + LEGACY_SIZE);

  logic [BASE_W-1:0] hole_base;
  logic [ADDR_W:0]   reloc_end;
  logic [ADDR_W:0]   hi_end;
  logic              hi_en;
  tgt_e              dec_tgt;
  logic [ADDR_W-1:0] dec_off;
  logic              accept;

  hole_base_reg #(.IDX_W(IDX_W), .LANES(BASE_W/8)) u_reg (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt_base),
    .wr(cfg_wr), .rd(cfg_rd), .idx(cfg_idx), .be(cfg_be),
    .wdata(cfg_wdata), .base_o(hole_base), .rdata_o(cfg_rdata)
  );

  hole_window_calc #(.ADDR_W(ADDR_W), .BASE_W(BASE_W),
                     .SPAN_LOG2(SPAN_LOG2), .NARROW(NARROW_ADDR)) u_win (
    .base(hole_base), .ram_size(ram_size),
    .reloc_end(reloc_end), .hi_end(hi_end), .hi_en(hi_en)
  );

  addr_classifier #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_cls (
    .addr(lk_addr), .base(hole_base), .ram_size(ram_size),
    .reloc_end(reloc_end), .hi_end(hi_end), .hi_en(hi_en),
    .tgt(dec_tgt), .offset(dec_off)
  );

  assign lk_ready = !rs_valid || rs_ready;
  assign accept   = lk_valid && lk_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid    <= 1'b0;
      rs_target   <= TGT_NONE;
      rs_unmapped <= 1'b0;
      rs_offset   <= '0;
    end else if (accept) begin
      rs_valid    <= 1'b1;
      rs_target   <= dec_tgt;
      rs_unmapped <= (dec_tgt == TGT_NONE);
      rs_offset   <= dec_off;
    end else if (rs_ready) begin
      rs_valid <= 1'b0;
    end
  end

  a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_target) && $stable(rs_offset)));
  a_r11_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rs_valid);
  a_r5_legacy: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && lk_addr >= ADDR_W'(LEGACY_LO) && lk_addr < LEG_END)
    |=> (rs_target == TGT_LEGACY));
  a_r6_low_hole: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && lk_addr[ADDR_W-1:BASE_W] == '0 && lk_addr[BASE_W-1:0] >= hole_base
     && !(lk_addr >= ADDR_W'(LEGACY_LO) && lk_addr < LEG_END))
    |=> (rs_target == TGT_PCI));
  a_r9_narrow_no_high_pci: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && NARROW_ADDR && lk_addr[ADDR_W-1:BASE_W] != '0)
    |=> (rs_target != TGT_PCI));
  a_r10_flag_only_none: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_unmapped) |-> (rs_offset == '0));
endmodule

// File: tb/pci_hole_decoder_tb_top.sv
module pci_hole_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_alt_base = 1'b0;
  logic [63:0] ram_size = 64'h1_8000_0000;
  logic        cfg_wr = 0, cfg_rd = 0;
  logic [5:0]  cfg_idx = 0;
  logic [3:0]  cfg_be = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic        lk_valid = 0, lk_ready, rs_ready = 1;
  logic [63:0] lk_addr = 0;
  logic        rs_valid, rs_unmapped;
  logic [1:0]  rs_target;
  logic [63:0] rs_offset;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pci_hole_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .strap_alt_base(strap_alt_base), .ram_size(ram_size),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_idx(cfg_idx), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_target(rs_target),
    .rs_unmapped(rs_unmapped), .rs_offset(rs_offset)
  );

  // behavioural reference model
  logic [31:0] m_base;
  logic [31:0] m_rdata;
  logic        m_valid;
  logic [1:0]  m_tgt;
  logic [63:0] m_off;
  string       m_tag;

  function automatic void ref_decode(input logic [63:0] a, input logic [31:0] b,
                                     input logic [63:0] ram, output logic [1:0] t,
                                     output logic [63:0] o, output string tag);
    longint unsigned ua = a, ub = b, ur = ram, moved, top;
    t = 2'd3; o = 0; tag = "R10";
    moved = (ur >= ub) ? ur - ub : 0;
    if (ua >= 64'hA0000 && ua < 64'hC0000) begin t = 2'd2; tag = "R5"; end
    else if (ua < 64'h1_0000_0000) begin
      if (ua >= ub) begin t = 2'd1; tag = "R6"; end
      else if (ua < ur) begin t = 2'd0; o = a; tag = "R7"; end
    end else if (ua - 64'h1_0000_0000 < moved) begin
      t = 2'd0; o = ua - 64'h1_0000_0000 + ub; tag = "R8";
    end else begin
      top = ua - 64'h1_0000_0000 - moved;   // distance into the high hole
      if (top < (64'd1 << 62)) begin t = 2'd1; tag = "R9"; end
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_base  <= strap_alt_base ? 32'hF000_0000 : 32'hE000_0000;
      m_rdata <= 0; m_valid <= 0; m_tgt <= 3; m_off <= 0; m_tag <= "R11";
    end else begin
      logic [1:0] t; logic [63:0] o; string tg;
      if (cfg_rd) m_rdata <= (cfg_idx == 6'h2C) ? m_base : 32'h0;
      if (cfg_wr && cfg_idx == 6'h2C)
        for (int k = 0; k < 4; k++)
          if (cfg_be[k]) m_base[8*k +: 8] <= cfg_wdata[8*k +: 8];
      if (lk_valid && (!m_valid || rs_ready)) begin
        ref_decode(lk_addr, m_base, ram_size, t, o, tg);   // old base: R4
        m_valid <= 1; m_tgt <= t; m_off <= o; m_tag <= tg;
      end else if (rs_ready) m_valid <= 0;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check("R11", 64'(rs_valid), 64'(m_valid));
    check("R11", 64'(lk_ready), 64'(!m_valid || rs_ready));
    check("R3", 64'(cfg_rdata), 64'(m_rdata));
    if (m_valid) begin
      check(m_tag, 64'(rs_target), 64'(m_tgt));
      check(m_tag, rs_offset, m_off);
      check("R10", 64'(rs_unmapped), 64'(m_tgt == 2'd3));
    end
  end

  task automatic look(input logic [63:0] a);
    @(negedge clk); lk_valid = 1; lk_addr = a;
    @(negedge clk); lk_valid = 0;
  endtask

  task automatic cfg_write(input logic [5:0] i, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk); cfg_wr = 1; cfg_idx = i; cfg_be = be; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic cfg_read(input logic [5:0] i, input string req, input logic [31:0] exp);
    @(negedge clk); cfg_rd = 1; cfg_idx = i;
    @(negedge clk); cfg_rd = 0;
    check(req, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic summary();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cfg_read(6'h2C, "R1", 32'hE000_0000);
    cfg_read(6'h10, "R3", 32'h0);
    // 6 GiB RAM, base 0xE000_0000: moved = 0xA000_0000
    look(64'h1000);                 // R7
    look(64'hA0000);                // R5
    look(64'hBFFFF);                // R5
    look(64'hC0000);                // R7
    look(64'hDFFF_FFFF);            // R7
    look(64'hE000_0000);            // R6
    look(64'hFFFF_FFFF);            // R6
    look(64'h1_0000_0000);          // R8 offset 0xE000_0000
    look(64'h1_9FFF_FFFF);          // R8
    look(64'h1_A000_0000);          // R9
    look(64'h4000_0001_9FFF_FFFF);  // R9 last byte
    look(64'h4000_0001_A000_0000);  // R10
    look(64'hFFFF_FFFF_FFFF_FFFF);  // R10
    // R2/R4: top lane only, lookup in the same cycle sees old base
    @(negedge clk);
    cfg_wr = 1; cfg_idx = 6'h2C; cfg_be = 4'b1000; cfg_wdata = 32'hC012_3456;
    lk_valid = 1; lk_addr = 64'hD000_0000;
    @(negedge clk);
    cfg_wr = 0;                      // lookup again: new base applies (R4)
    @(negedge clk); lk_valid = 0;
    check("R4", 64'(rs_target), 64'd1);
    cfg_read(6'h2C, "R2", 32'hC000_0000);
    cfg_write(6'h2D, 4'hF, 32'h1234_5678);
    cfg_read(6'h2C, "R2", 32'hC000_0000);
    cfg_write(6'h2C, 4'b0001, 32'hAAAA_AA55);
    cfg_read(6'h2C, "R3", 32'hC000_0055);
    cfg_write(6'h2C, 4'hF, 32'hC000_0000);
    // small RAM: nothing moved
    ram_size = 64'h8000_0000;
    look(64'h1_0000_0000);          // R9
    look(64'h9000_0000);            // R10
    look(64'h7FFF_FFFF);            // R7
    // back-pressure with a stream of lookups
    @(negedge clk); lk_valid = 1; lk_addr = 64'h0500;
    rs_ready = 0;
    repeat (3) @(negedge clk);
    lk_addr = 64'hC100_0000;
    rs_ready = 1;
    @(negedge clk); lk_valid = 0;
    ram_size = 64'h2_0000_0000;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      lk_valid = $urandom_range(0, 1);
      rs_ready = ($urandom_range(0, 3) != 0);
      case ($urandom_range(0, 3))
        0: lk_addr = 64'($urandom);
        1: lk_addr = {31'h0, $urandom_range(0, 7), 32'($urandom)};
        2: lk_addr = 64'h000A_0000 + 64'($urandom_range(0, 'h3FFFF));
        default: lk_addr = {$urandom, $urandom};
      endcase
    end
    @(negedge clk); lk_valid = 0; rs_ready = 1;
    // R1 alternate strap
    strap_alt_base = 1; rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    cfg_read(6'h2C, "R1", 32'hF000_0000);
    repeat (2) @(negedge clk);
    summary();
  end
endmodule